// File: doc/BRIEF.md
# Disk Word-Time Wakeup Synchronizer

This block tells the disk word task that another 16-bit word has passed under the head. A small counter runs on the drive's read clock and counts bit cells. On the sixteenth bit cell it raises a done flag and flips a toggle flip-flop. The toggle level crosses into the system-clock domain through a two-flop synchronizer. A third flop follows the synchronizer and acts as an edge detector, so every flip of the toggle becomes exactly one single-cycle wakeup request for the task scheduler.

The block also holds the allow command and the init status bit. The allow command is loaded only when the load-command strobe fires, and it takes its value from the command data bit. While allow is low, the counter, the toggle and the synchronizer are all held cleared, and init is forced on. Once allow is high, init stays on until the word task runs a cycle with its block signal raised. That marks the end of the first pass of the task.

Top module: `word_wake_sync`

## Requirements
- R1: The done flag rises at the sixteenth read-clock rising edge after allow goes high and falls at the next read-clock rising edge.
- R2: Each group of 16 read-clock edges produces exactly one wakeup request, and that request lasts exactly one system-clock cycle.
- R3: If the sixteenth read-clock edge coincides with a system-clock falling edge, the wakeup is low after the first following system-clock rising edge, high after the second, and low again after the third.
- R4: While allow is low, read-clock edges produce neither a done flag nor a wakeup, and raising allow restarts the bit count from zero.
- R5: The init status bit reads 1 out of reset and in every cycle that follows a cycle with allow low.
- R6: With allow high, init clears one cycle after a cycle in which both block and word-task-active are high. Block raised without word-task-active leaves init set.
- R7: Allow takes the value of the command allow input only on a cycle with the load-command strobe high. A change on the command input without the strobe has no effect.
- R8: The bit counter wraps to zero after each word and keeps counting without dropping an edge, so 31 edges give one wakeup and 32 edges give two.
- R9: Out of reset the wakeup and the done flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, system domain |
| rd_clk | input | 1 | Bit-cell read clock from the drive |
| ld_cmd | input | 1 | Load-command strobe from the microinstruction decoder |
| cmd_allow | input | 1 | Allow value loaded on the strobe |
| word_task | input | 1 | High while the disk word task owns the cycle |
| blk | input | 1 | Task block request from the sequencer |
| wake_req | output | 1 | Single-cycle wakeup request for the word task |
| init_flag | output | 1 | Init status bit |
| word_done | output | 1 | Done flag in the read-clock domain |

## Verification
The bench counts wakeup pulses over bursts of 15, 16, 17, 31, 32 and 48 read-clock edges. A counter that wraps one bit early or late, or that drops an edge at the wrap, gives the wrong number of pulses. A pulse that stretches over two cycles counts twice, so a broken edge detector also shows up. The bench places one toggle on a known system-clock phase and checks that the wakeup appears after exactly two synchronizer flops. It also checks that a burst which begins before allow drops and ends after allow rises cannot complete a word early. The init checks cover block raised without the word task, and a command change made without the strobe, which a decoder that latches loosely would accept.

// File: rtl/wdw_pkg.sv
`timescale 1ns/1ps
package wdw_pkg;
    // Command and status state of the system-clock domain.
    typedef struct packed {
        logic allow;
        logic init;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{allow: 1'b0, init: 1'b1};
endpackage

// File: rtl/wdw_bit_counter.sv
`timescale 1ns/1ps
// Read-clock domain: counts bit cells and flips a toggle once per word.
module wdw_bit_counter #(
    parameter int BITS_PER_WORD = 16
) (
    input  logic rd_clk,
    input  logic hold,
    output logic done,
    output logic tgl
);
    localparam int CNT_W = $clog2(BITS_PER_WORD);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BITS_PER_WORD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             tgl;
    } st_t;

    st_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.cnt == LAST_C);
        st_d.cnt  = at_last ? '0 : st_q.cnt + 1'b1;
        st_d.done = at_last;
        st_d.tgl  = st_q.tgl ^ at_last;
    end

    always_ff @(posedge rd_clk or posedge hold) begin
        if (hold) st_q <= '0;
        else      st_q <= st_d;
    end

    assign done = st_q.done;
    assign tgl  = st_q.tgl;
endmodule

// File: rtl/wdw_toggle_sync.sv
`timescale 1ns/1ps
// System-clock domain: synchronizes the toggle and turns each flip into a pulse.
module wdw_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tgl_in,
    output logic pulse
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) st_d.chain = '0;
        else       st_d.chain = {st_q.chain[CHAIN_W-2:0], tgl_in};
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.chain[CHAIN_W-1] ^ st_q.chain[CHAIN_W-2];
endmodule

// File: rtl/wdw_cmd_ctrl.sv
`timescale 1ns/1ps
// Allow command register and init status bit.
module wdw_cmd_ctrl
    import wdw_pkg::*;
(
    input  logic sys_clk,
    input  logic rst_n,
    input  logic ld_cmd,
    input  logic cmd_allow,
    input  logic word_task,
    input  logic blk,
    output logic allow,
    output logic init
);
    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_cmd) st_d.allow = cmd_allow;
        if (!st_q.allow)            st_d.init = 1'b1;
        else if (blk && word_task)  st_d.init = 1'b0;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_RESET;
        else        st_q <= st_d;
    end

    assign allow = st_q.allow;
    assign init  = st_q.init;
endmodule

// File: rtl/word_wake_sync.sv
`timescale 1ns/1ps
module word_wake_sync #(
    parameter int BITS_PER_WORD = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic rd_clk,
    input  logic ld_cmd,
    input  logic cmd_allow,
    input  logic word_task,
    input  logic blk,
    output logic wake_req,
    output logic init_flag,
    output logic word_done
);
    logic allow_w;
    logic hold_w;
    logic tgl_w;

    wdw_cmd_ctrl u_ctl (
        .sys_clk   (sys_clk),
        .rst_n     (rst_n),
        .ld_cmd    (ld_cmd),
        .cmd_allow (cmd_allow),
        .word_task (word_task),
        .blk       (blk),
        .allow     (allow_w),
        .init      (init_flag)
    );

    // Read-domain logic is held cleared for as long as allow is low.
    assign hold_w = ~allow_w;

    wdw_bit_counter #(.BITS_PER_WORD(BITS_PER_WORD)) u_cnt (
        .rd_clk (rd_clk),
        .hold   (hold_w),
        .done   (word_done),
        .tgl    (tgl_w)
    );

    wdw_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .clear   (hold_w),
        .tgl_in  (tgl_w),
        .pulse   (wake_req)
    );
endmodule

// File: rtl/wdw_checker.sv
`timescale 1ns/1ps
module wdw_checker (
    input logic sys_clk,
    input logic rst_n,
    input logic rd_clk,
    input logic ld_cmd,
    input logic word_task,
    input logic blk,
    input logic allow_q,
    input logic wake_req,
    input logic init_flag,
    input logic word_done
);
    // R2: a wakeup never spans two cycles
    p_wake_single_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R4: no wakeup once allow has been low for a full cycle
    p_no_wake_idle_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (!allow_q && !$past(allow_q)) |-> !wake_req);

    // R5: init forced on after a cycle with allow low
    p_init_forced_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !allow_q |=> init_flag);

    // R6: init clears after the word task blocks
    p_init_clear_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (allow_q && blk && word_task) |=> !init_flag);

    // R7: allow only moves on the load strobe
    p_allow_hold_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !ld_cmd |=> $stable(allow_q));

    // R1: done flag lasts one read-clock cycle
    p_done_single_r1: assert property (@(posedge rd_clk) disable iff (!rst_n || !allow_q)
        word_done |=> !word_done);
endmodule

bind word_wake_sync wdw_checker u_chk (
    .sys_clk   (sys_clk),
    .rst_n     (rst_n),
    .rd_clk    (rd_clk),
    .ld_cmd    (ld_cmd),
    .word_task (word_task),
    .blk       (blk),
    .allow_q   (allow_w),
    .wake_req  (wake_req),
    .init_flag (init_flag),
    .word_done (word_done)
);

// File: tb/word_wake_sync_tb_top.sv
`timescale 1ns/1ps
module word_wake_sync_tb_top;
    logic sys_clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_clk = 1'b0;
    logic ld_cmd = 1'b0;
    logic cmd_allow = 1'b0;
    logic word_task = 1'b0;
    logic blk = 1'b0;
    logic wake_req, init_flag, word_done;

    int nchk = 0;
    int nfail = 0;
    int wake_cnt = 0;

    always #2.5 sys_clk = ~sys_clk;   // 200 MHz

    word_wake_sync dut_i (
        .sys_clk(sys_clk), .rst_n(rst_n), .rd_clk(rd_clk), .ld_cmd(ld_cmd),
        .cmd_allow(cmd_allow), .word_task(word_task), .blk(blk),
        .wake_req(wake_req), .init_flag(init_flag), .word_done(word_done)
    );

    always @(negedge sys_clk) if (wake_req) wake_cnt++;

    // {allow, read-clock edges, expected wakeups}
    typedef struct packed {
        bit       en;
        bit [7:0] pulses;
        bit [3:0] wakes;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{en: 1'b1, pulses: 8'd16, wakes: 4'd1},   // R2
        '{en: 1'b1, pulses: 8'd15, wakes: 4'd0},   // R2
        '{en: 1'b1, pulses: 8'd32, wakes: 4'd2},   // R8
        '{en: 1'b1, pulses: 8'd31, wakes: 4'd1},   // R8
        '{en: 1'b1, pulses: 8'd48, wakes: 4'd3},   // R8
        '{en: 1'b0, pulses: 8'd32, wakes: 4'd0}    // R4
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic set_allow(input logic v);
        @(negedge sys_clk);
        ld_cmd = 1'b1; cmd_allow = v;
        @(negedge sys_clk);
        ld_cmd = 1'b0;
        cycles(2);
    endtask

    task automatic rd_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge sys_clk); rd_clk = 1'b1;
            cycles(2);         rd_clk = 1'b0;
            cycles(1);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        cycles(3);
        // R9 / R5: reset state
        check("R9 wake in reset", int'(wake_req), 0);
        check("R9 done in reset", int'(word_done), 0);
        check("R5 init in reset", int'(init_flag), 1);
        rst_n = 1'b1;
        cycles(2);
        check("R5 init after reset", int'(init_flag), 1);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            set_allow(1'b0);
            set_allow(VECS[v].en);
            wake_cnt = 0;
            rd_pulses(int'(VECS[v].pulses));
            cycles(6);
            check($sformatf("R2/R4/R8 vector %0d wake count", v), wake_cnt, int'(VECS[v].wakes));
        end

        // R1 and R3: edge placement of done and wakeup
        set_allow(1'b0);
        set_allow(1'b1);
        rd_pulses(15);
        cycles(4);
        wake_cnt = 0;
        @(negedge sys_clk); rd_clk = 1'b1;
        #0.5;
        check("R1 done after 16th edge", int'(word_done), 1);
        @(negedge sys_clk);
        check("R3 wake after first edge", int'(wake_req), 0);
        @(negedge sys_clk);
        check("R3 wake after second edge", int'(wake_req), 1);
        rd_clk = 1'b0;
        @(negedge sys_clk);
        check("R3 wake after third edge", int'(wake_req), 0);
        cycles(4);
        check("R2 single pulse", wake_cnt, 1);
        rd_pulses(1);
        check("R1 done clears on 17th edge", int'(word_done), 0);

        // R4: dropping allow mid-word restarts the count
        set_allow(1'b0);
        set_allow(1'b1);
        wake_cnt = 0;
        rd_pulses(10);
        set_allow(1'b0);
        set_allow(1'b1);
        rd_pulses(6);
        cycles(6);
        check("R4 count restarted, no early wake", wake_cnt, 0);
        rd_pulses(10);
        cycles(6);
        check("R4 wake after full fresh word", wake_cnt, 1);

        // R7: command value without strobe is ignored
        set_allow(1'b0);
        @(negedge sys_clk); cmd_allow = 1'b1;
        cycles(3);
        wake_cnt = 0;
        rd_pulses(16);
        cycles(6);
        check("R7 no wake without strobe", wake_cnt, 0);
        check("R7 done stays low without strobe", int'(word_done), 0);
        check("R7 init still set", int'(init_flag), 1);

        // R5 / R6: init behaviour
        set_allow(1'b1);
        check("R5 init set before first block", int'(init_flag), 1);
        @(negedge sys_clk); blk = 1'b1; word_task = 1'b0;
        @(negedge sys_clk);
        check("R6 block without word task keeps init", int'(init_flag), 1);
        word_task = 1'b1;
        @(negedge sys_clk);
        check("R6 init clears on block in word task", int'(init_flag), 0);
        blk = 1'b0; word_task = 1'b0;
        cycles(2);
        check("R6 init stays clear", int'(init_flag), 0);
        set_allow(1'b0);
        check("R5 init forced when allow low", int'(init_flag), 1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule